// File: doc/BRIEF.md
# Affine Check-Tag Predictor

This block predicts the two-byte check tag that belongs to a frame from the frame's 16-bit payload value alone. It does not need the polynomial that produces the tag. The tag is an affine function of the payload bits, so the block stores two kinds of entries:

- one base tag, which is the tag of the all-zero payload;
- one basis tag for each single-bit payload.

A prediction is the XOR of the basis tags of every set payload bit. The base tag is XORed in as well when the number of set bits is even.

After reset the entries hold the values of a fixed frame family. For these values every predicted tag equals the 16-bit CRC of a six-byte frame. A small write port can replace any entry, so the same hardware can serve another frame family once its base and single-bit tags are known.

A caller presents a payload, together with the tag it observed, and pulses a request strobe. One cycle later the block returns three things: the predicted tag, a valid pulse, and a mismatch flag that tells whether the observed tag differs from the prediction.

Top module: `affine_tag_predictor`

## Requirements
- R1: After reset, tag_out is 0x0000 and tag_valid and tag_mismatch are 0. The entries return to their defaults:
  - base tag (index 0): 0xBB83;
  - indices 1..8: 7A43, 3A42, BA40, BA45, BA4F, BA5B, BA73, BA23;
  - indices 9..16: BA13, BAE3, B943, BC43, B643, A243, 8A43, DA43.
- R2: The predicted tag is the XOR of entry i+1 for every set payload bit i. Entry 0 is XORed in as well when the count of set bits is even, and this includes the zero payload.
- R3: A request at a clock edge gives tag_valid high for exactly the following cycle, with tag_out holding the prediction. Without a request, tag_valid is 0 and tag_out keeps its last value.
- R4: tag_mismatch is 1 in a valid cycle exactly when the obs_tag sampled with the request differs from the prediction. Outside valid cycles it is 0.
- R5: A write with wr_idx 0 replaces the base tag, and a write with wr_idx k in 1..16 replaces the tag of payload bit k-1. A write takes effect at its clock edge. A request at the same edge still uses the old entry.
- R6: Writes with wr_idx 17..31 change no entry.
- R7: With the default entries the block predicts:

  | Payload | Tag |
  |---|---|
  | 0x0000 | 0xBB83 |
  | 0x0001 | 0x7A43 |
  | 0xFFFF | 0xBA33 |
  | 0xFFFE | 0x7BF3 |
  | 0xDDDD | 0x228A |
  | 0xEEEE | 0x766F |

  The tag for 0x0001 is also the XOR of the tags for 0x0000, 0xFFFE and 0xFFFF.
- R8: With the default entries, the tag for every payload P equals the following CRC, written as {low byte, high byte}:
  - the frame is the bytes D2, 06, 00, 8A, P[15:8], P[7:0];
  - the initial value is 0xFFFF;
  - each byte is XORed into the low end of the CRC;
  - the CRC is then shifted right 8 times, XORing in 0xA001 whenever the bit shifted out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 5 | Entry index: 0 is the base tag, k is payload bit k-1 |
| wr_data | input | 16 | Tag value to store |
| req | input | 1 | Prediction request strobe |
| payload | input | 16 | Payload value to predict for |
| obs_tag | input | 16 | Observed tag to compare with the prediction |
| tag_out | output | 16 | Registered predicted tag |
| tag_valid | output | 1 | One-cycle pulse one cycle after req |
| tag_mismatch | output | 1 | Observed tag differed from prediction (valid cycles only) |

## Verification
The bench sweeps all 65536 payloads against its own bit-serial CRC of the full frame.

- A design that got the parity rule backwards, folding in the base tag on odd bit counts, would be wrong on roughly every payload.
- A design that shifted the basis index by one would fail the single-bit payloads.

A second sweep runs over reloaded entries and uses a different affine form. In that form each set bit contributes its basis tag XOR the base tag, on top of one base tag. This exposes a write decode that skips or aliases an index.

The bench also checks three corner cases:
- a write and a request at the same edge must return the old value;
- out-of-range indices must leave every prediction alone;
- a deliberately wrong observed tag must raise the mismatch flag only in its own valid cycle.

// File: rtl/atp_pkg.sv
package atp_pkg;

  // Default entry contents: index 0 is the zero-payload tag, index k the
  // tag of a payload with only bit k-1 set.
  function automatic logic [15:0] default_tag(input int unsigned idx);
    logic [15:0] v;
    case (idx)
      0:  v = 16'hBB83;
      1:  v = 16'h7A43;
      2:  v = 16'h3A42;
      3:  v = 16'hBA40;
      4:  v = 16'hBA45;
      5:  v = 16'hBA4F;
      6:  v = 16'hBA5B;
      7:  v = 16'hBA73;
      8:  v = 16'hBA23;
      9:  v = 16'hBA13;
      10: v = 16'hBAE3;
      11: v = 16'hB943;
      12: v = 16'hBC43;
      13: v = 16'hB643;
      14: v = 16'hA243;
      15: v = 16'h8A43;
      16: v = 16'hDA43;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/atp_table.sv
module atp_table #(
  parameter int unsigned PAY_W = 16,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned IDX_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [TAG_W-1:0]            wr_data,
  output logic [PAY_W:0][TAG_W-1:0]   entries,
  output logic                        wr_hit
);
  import atp_pkg::*;

  // A write lands only when its index names an existing entry.
  assign wr_hit = wr_en && (wr_idx <= IDX_W'(PAY_W));

  for (genvar i = 0; i <= PAY_W; i++) begin : g_entry
    localparam logic [TAG_W-1:0] RST_VAL = TAG_W'(default_tag(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entries[i] <= RST_VAL;
      end else if (wr_hit && (wr_idx == IDX_W'(i))) begin
        entries[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/atp_combine.sv
module atp_combine #(
  parameter int unsigned PAY_W = 16,
  parameter int unsigned TAG_W = 16
) (
  input  logic [PAY_W-1:0]            payload,
  input  logic [PAY_W:0][TAG_W-1:0]   entries,
  output logic [TAG_W-1:0]            pred_tag,
  output logic                        even_weight
);

  // XOR of the basis tags of the set bits, plus the base tag when an even
  // number of bits is set.
  function automatic logic [TAG_W-1:0] affine_predict(
    input logic [PAY_W-1:0]          p,
    input logic [PAY_W:0][TAG_W-1:0] e
  );
    logic [TAG_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < PAY_W; b++) begin
      if (p[b]) acc ^= e[b+1];
    end
    if (!(^p)) acc ^= e[0];
    return acc;
  endfunction

  assign even_weight = ~(^payload);
  assign pred_tag    = affine_predict(payload, entries);

endmodule

// File: rtl/affine_tag_predictor.sv
module affine_tag_predictor #(
  parameter int unsigned PAY_W = 16,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_data,
  input  logic              req,
  input  logic [PAY_W-1:0]  payload,
  input  logic [TAG_W-1:0]  obs_tag,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_valid,
  output logic              tag_mismatch
);

  logic [PAY_W:0][TAG_W-1:0] entries;
  logic                      wr_hit;
  logic [TAG_W-1:0]          pred_tag;
  logic                      even_weight;
  logic [TAG_W-1:0]          base_tag;
  logic                      obs_differs;

  atp_table #(.PAY_W(PAY_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .entries (entries),
    .wr_hit  (wr_hit)
  );

  atp_combine #(.PAY_W(PAY_W), .TAG_W(TAG_W)) u_combine (
    .payload     (payload),
    .entries     (entries),
    .pred_tag    (pred_tag),
    .even_weight (even_weight)
  );

  assign base_tag    = entries[0];
  assign obs_differs = (pred_tag != obs_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_out      <= '0;
      tag_valid    <= 1'b0;
      tag_mismatch <= 1'b0;
    end else begin
      tag_valid    <= req;
      tag_mismatch <= req && obs_differs;
      if (req) tag_out <= pred_tag;
    end
  end

endmodule

// File: rtl/atp_checker.sv
module atp_checker #(
  parameter int unsigned PAY_W = 16,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned IDX_W = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [IDX_W-1:0]          wr_idx,
  input logic                      req,
  input logic [PAY_W-1:0]          payload,
  input logic [TAG_W-1:0]          obs_tag,
  input logic [TAG_W-1:0]          tag_out,
  input logic                      tag_valid,
  input logic                      tag_mismatch,
  input logic [PAY_W:0][TAG_W-1:0] entries,
  input logic [TAG_W-1:0]          base_tag
);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> tag_valid); // R3
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !tag_valid); // R3
  AST_TAG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(tag_out)); // R3
  AST_MISMATCH_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tag_mismatch |-> tag_valid); // R4
  AST_MISMATCH_VS_OBS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (tag_mismatch == (tag_out != $past(obs_tag)))); // R4
  AST_ZERO_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && payload == '0) |=> (tag_out == $past(base_tag))); // R2
  AST_BIT0_IS_BASIS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && payload == PAY_W'(1)) |=> (tag_out == $past(entries[1]))); // R2
  AST_BAD_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > IDX_W'(PAY_W)) |=> $stable(entries)); // R6
  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(entries)); // R5

endmodule

bind affine_tag_predictor atp_checker #(.PAY_W(PAY_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_atp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .req          (req),
  .payload      (payload),
  .obs_tag      (obs_tag),
  .tag_out      (tag_out),
  .tag_valid    (tag_valid),
  .tag_mismatch (tag_mismatch),
  .entries      (entries),
  .base_tag     (base_tag)
);

// File: tb/affine_tag_predictor_bench.sv
`timescale 1ns/1ps
module affine_tag_predictor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        req = 1'b0;
  logic [15:0] payload = '0;
  logic [15:0] obs_tag = '0;
  logic [15:0] tag_out;
  logic        tag_valid;
  logic        tag_mismatch;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] model_tbl [17];

  always #5 clk = ~clk;

  affine_tag_predictor u_affine_tag_predictor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req(req), .payload(payload), .obs_tag(obs_tag),
    .tag_out(tag_out), .tag_valid(tag_valid), .tag_mismatch(tag_mismatch)
  );

  function automatic logic [15:0] crc_frame(input logic [15:0] p);
    logic [7:0]  bytes [6];
    logic [15:0] c;
    bytes[0] = 8'hD2; bytes[1] = 8'h06; bytes[2] = 8'h00; bytes[3] = 8'h8A;
    bytes[4] = p[15:8]; bytes[5] = p[7:0];
    c = 16'hFFFF;
    for (int i = 0; i < 6; i++) begin
      c[7:0] = c[7:0] ^ bytes[i];
      for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return {c[7:0], c[15:8]};
  endfunction

  // Affine form: base, plus (basis ^ base) for each set bit.
  function automatic logic [15:0] model_pred(input logic [15:0] p);
    logic [15:0] acc;
    acc = model_tbl[0];
    for (int b = 0; b < 16; b++)
      if (p[b]) acc = acc ^ model_tbl[b+1] ^ model_tbl[0];
    return acc;
  endfunction

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic one_req(input string rtag, input logic [15:0] p,
                         input logic [15:0] obs, input logic [15:0] exp);
    @(negedge clk);
    req = 1'b1; payload = p; obs_tag = obs;
    @(negedge clk);
    req = 1'b0;
    check(rtag, "tag", 32'(tag_out), 32'(exp));
    check(rtag, "valid", 32'(tag_valid), 32'd1);
    check(rtag, "mismatch", 32'(tag_mismatch), 32'(obs != exp));
  endtask

  task automatic write_entry(input int idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] prev_exp;
    logic [15:0] prev_obs;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset tag", 32'(tag_out), 32'd0);
    check("R1", "reset valid", 32'(tag_valid), 32'd0);
    check("R1", "reset mismatch", 32'(tag_mismatch), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 stated vectors, R4 mismatch sense
    one_req("R7", 16'h0000, 16'hBB83, 16'hBB83);
    one_req("R7", 16'h0001, 16'h7A43, 16'h7A43);
    one_req("R7", 16'hFFFF, 16'hBA33, 16'hBA33);
    one_req("R7", 16'hFFFE, 16'h7BF3, 16'h7BF3);
    one_req("R7", 16'hDDDD, 16'h228A, 16'h228A);
    one_req("R7", 16'hEEEE, 16'h766F, 16'h766F);
    check("R7", "affine identity", 32'(16'hBB83 ^ 16'h7BF3 ^ 16'hBA33), 32'h7A43);
    one_req("R4", 16'h0001, 16'h7A42, 16'h7A43);

    // R8/R2/R3/R4 exhaustive back-to-back sweep against the frame CRC
    prev_exp = '0; prev_obs = '0;
    for (int k = 0; k <= 65536; k++) begin
      @(negedge clk);
      if (k > 0) begin
        if (tag_out !== prev_exp || tag_valid !== 1'b1 || tag_mismatch !== (prev_obs != prev_exp)) begin
          check("R8", "sweep tag", 32'(tag_out), 32'(prev_exp));
          check("R3", "sweep valid", 32'(tag_valid), 32'd1);
          check("R4", "sweep mismatch", 32'(tag_mismatch), 32'(prev_obs != prev_exp));
        end else begin
          checks++;
        end
      end
      if (k < 65536) begin
        req = 1'b1;
        payload = 16'(k);
        prev_exp = crc_frame(16'(k));
        prev_obs = (k % 7 == 3) ? (prev_exp ^ 16'h0100) : prev_exp;
        obs_tag = prev_obs;
      end else begin
        req = 1'b0;
      end
    end

    // R3 idle: no valid, tag held
    held = tag_out;
    @(negedge clk);
    check("R3", "idle valid", 32'(tag_valid), 32'd0);
    check("R3", "idle hold", 32'(tag_out), 32'(held));
    check("R4", "idle mismatch", 32'(tag_mismatch), 32'd0);

    // R5 write and request at the same edge: old base returned
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd0; wr_data = 16'h1234;
    req = 1'b1; payload = 16'h0000; obs_tag = 16'hBB83;
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    check("R5", "same-edge old base", 32'(tag_out), 32'hBB83);
    one_req("R5", 16'h0000, 16'h1234, 16'h1234);

    // R5 reload all entries with fresh values
    for (int i = 0; i <= 16; i++) begin
      model_tbl[i] = 16'((i * 16'h1357) ^ 16'hA5A5 ^ (i << 11));
      write_entry(i, model_tbl[i]);
    end
    // R6 out-of-range writes leave every entry alone
    write_entry(17, 16'hFFFF);
    write_entry(31, 16'h0F0F);
    write_entry(24, 16'h5555);

    for (int b = 0; b < 16; b++)
      one_req("R5", 16'(1 << b), model_tbl[b+1], model_tbl[b+1]);
    one_req("R6", 16'h0000, model_tbl[0], model_tbl[0]);

    // R2/R6 strided sweep with reloaded entries
    for (int k = 0; k < 4096; k++) begin
      logic [15:0] p;
      p = 16'(k * 16'h9E37 + 16'h0011);
      @(negedge clk);
      req = 1'b1; payload = p; obs_tag = model_pred(p);
      @(negedge clk);
      req = 1'b0;
      check("R2", "reloaded sweep", 32'(tag_out), 32'(model_pred(p)));
    end

    // R1 reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset tag again", 32'(tag_out), 32'd0);
    rst_n = 1'b1;
    one_req("R1", 16'h0000, 16'hBB83, 16'hBB83);
    one_req("R1", 16'h8000, 16'hDA43, 16'hDA43);

    finish_run();
  end

endmodule